// File: doc/BRIEF.md
# Hybrid radix-3 parallel prefix adder

This block is a purely combinational 16-bit adder with a carry input. It takes two operands and a one-bit carry, and returns a 16-bit sum and a carry output. It contains no registers, so a change on any input appears on the outputs within the same cycle. It is meant to sit inside a datapath stage that leaves room for three gate levels of pre- and post-processing plus a four-level carry network.

The carry input is treated as one extra, least significant prefix node. That node generates when the carry is set and never propagates. This gives seventeen nodes, and the network splits them into two segments:

- **Lower segment.** The lowest eight nodes (the carry input and operand bits 0 to 6) are resolved by a two-input Kogge-Stone network that has three levels.
- **Upper segment.** The upper nine nodes (operand bits 7 to 15) are reduced within their own segment by three-input merge cells. Spans at distance d and 2d are merged in one level, so nine nodes need only two levels.
- **Join.** A final row of generate-only cells combines each upper group with the lower segment's carry.

The critical path toward the most significant bit is therefore four cell levels. That is no more than a full radix-2 tree needs. A parameter can swap the lower segment for a rippled chain.

Top module: `hybrid_prefix_adder`

## Requirements
- R1: For every input combination, the 17-bit value {cout, sum} equals a + b + cin taken as unsigned integers.
- R2: The carry input enters at the least significant position: sum[0] equals a[0] XOR b[0] XOR cin.
- R3: When every bit position propagates (a XOR b is all ones), cout equals cin. The sum is then 16'hFFFF when cin is 0 and 16'h0000 when cin is 1.
- R4: When both operands are 16'hFFFF, cout is 1 and sum is 16'hFFFE with cin = 0 or 16'hFFFF with cin = 1.
- R5: A carry travels the whole word: 16'hFFFF + 16'h0001 with cin = 0 gives sum 16'h0000 and cout 1. The same sum and cout result from 16'hFFFF + 16'h0000 with cin = 1.
- R6: sum[7:0] depends only on a[7:0], b[7:0] and cin, so changing a[15:8] and b[15:8] leaves it unchanged. A carry out of the lower byte reaches bit 8: 16'h00FF + 16'h0001 gives 16'h0100.
- R7: The outputs are combinational. A new input vector is reflected on sum and cout without any clock edge.
- R8: With both operands zero, the outputs follow the carry input: sum is 16'h0000 and cout is 0 for cin = 0, and sum is 16'h0001 for cin = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand, unsigned |
| b | input | 16 | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 15 |

## Verification
The checks on this block are immediate and combinational, so they assume that a, b and cin hold known two-state values and are evaluated only once the network has settled on them. They make no claim about transient values while operands change. To stay within that assumption, the stimulus presents each operand pair exactly once per clock, shortly after the rising edge. It then reads the result half a period later, and changes nothing while the result is being compared. Corner vectors come first: carry chains across the whole word, across the segment boundary and across fully propagating words. After them comes a long run of uniformly random operands and carry values.

// File: rtl/hybrid_prefix_adder_pkg.sv
`timescale 1ns/1ps
package hybrid_prefix_adder_pkg;

  // integer helpers for elaboration-time sizing
  function automatic int int_pow(input int base, input int expo);
    int acc;
    acc = 1;
    for (int i = 0; i < expo; i++) acc = acc * base;
    return acc;
  endfunction

  function automatic int levels_for(input int radix, input int nodes);
    int reach;
    int lv;
    reach = 1;
    lv = 0;
    while (reach < nodes) begin
      reach = reach * radix;
      lv++;
    end
    return lv;
  endfunction

  // per-bit pre-processing
  function automatic logic bit_gen(input logic x, input logic y);
    return x & y;
  endfunction

  function automatic logic bit_prop(input logic x, input logic y);
    return x ^ y;
  endfunction

  // two-span merge: high span over low span
  function automatic logic merge2_g(input logic g_hi, input logic p_hi, input logic g_lo);
    return g_hi | (p_hi & g_lo);
  endfunction

  function automatic logic merge2_p(input logic p_hi, input logic p_lo);
    return p_hi & p_lo;
  endfunction

  // three-span merge: left (most significant), middle, right
  function automatic logic merge3_g(input logic g_l, input logic p_l,
                                    input logic g_m, input logic p_m,
                                    input logic g_r);
    return g_l | (p_l & g_m) | (p_l & p_m & g_r);
  endfunction

  function automatic logic merge3_p(input logic p_l, input logic p_m, input logic p_r);
    return p_l & p_m & p_r;
  endfunction

endpackage

// File: rtl/hpa_gp_front.sv
`timescale 1ns/1ps
module hpa_gp_front
  import hybrid_prefix_adder_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W:0]   node_g,
  output logic [W:1]   node_p
);
  // node 0 is the carry input: it generates on cin and never propagates
  assign node_g[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign node_g[i+1] = bit_gen(a[i], b[i]);
    assign node_p[i+1] = bit_prop(a[i], b[i]);
  end
endmodule

// File: rtl/hpa_low_tree.sv
`timescale 1ns/1ps
module hpa_low_tree
  import hybrid_prefix_adder_pkg::*;
#(
  parameter int N      = 8,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [N-1:0] g_in,
  input  logic [N-1:1] p_in,
  output logic [N-1:0] grp
);
  // grp[k] is the generate of nodes k down to 0, i.e. the carry into bit k
  if (RIPPLE) begin : g_chain
    assign grp[0] = g_in[0];
    for (genvar k = 1; k < N; k++) begin : g_step
      assign grp[k] = merge2_g(g_in[k], p_in[k], grp[k-1]);
    end
  end else begin : g_ks
    localparam int L = levels_for(2, N);
    logic [N-1:0] gl [0:L];
    logic [N-1:0] pl [0:L-1];
    assign gl[0] = g_in;
    assign pl[0] = {p_in, 1'b0};

    for (genvar l = 0; l < L; l++) begin : g_lvl
      localparam int D = int_pow(2, l);
      for (genvar j = 0; j < N; j++) begin : g_node
        if (j >= D) begin : g_cell
          assign gl[l+1][j] = merge2_g(gl[l][j], pl[l][j], gl[l][j-D]);
          if (l < L-1) begin : g_pk
            assign pl[l+1][j] = merge2_p(pl[l][j], pl[l][j-D]);
          end
        end else begin : g_pass
          assign gl[l+1][j] = gl[l][j];
          if (l < L-1) begin : g_pp
            assign pl[l+1][j] = pl[l][j];
          end
        end
      end
    end
    assign grp = gl[L];
  end
endmodule

// File: rtl/hpa_high_tree.sv
`timescale 1ns/1ps
module hpa_high_tree
  import hybrid_prefix_adder_pkg::*;
#(
  parameter int N = 9
) (
  input  logic [N-1:0] g_in,
  input  logic [N-1:0] p_in,
  output logic [N-1:0] grp_g,
  output logic [N-1:0] grp_p
);
  // radix-3 prefix over the segment; at level l node j merges j, j-3^l, j-2*3^l
  localparam int L = levels_for(3, N);

  logic [N-1:0] gl [0:L];
  logic [N-1:0] pl [0:L];
  assign gl[0] = g_in;
  assign pl[0] = p_in;

  for (genvar l = 0; l < L; l++) begin : g_lvl
    localparam int D = int_pow(3, l);
    for (genvar j = 0; j < N; j++) begin : g_node
      if (j >= 2*D) begin : g_tri
        assign gl[l+1][j] = merge3_g(gl[l][j], pl[l][j], gl[l][j-D], pl[l][j-D], gl[l][j-2*D]);
        assign pl[l+1][j] = merge3_p(pl[l][j], pl[l][j-D], pl[l][j-2*D]);
      end else if (j >= D) begin : g_duo
        assign gl[l+1][j] = merge2_g(gl[l][j], pl[l][j], gl[l][j-D]);
        assign pl[l+1][j] = merge2_p(pl[l][j], pl[l][j-D]);
      end else begin : g_pass
        assign gl[l+1][j] = gl[l][j];
        assign pl[l+1][j] = pl[l][j];
      end
    end
  end

  assign grp_g = gl[L];
  assign grp_p = pl[L];
endmodule

// File: rtl/hpa_sum_back.sv
`timescale 1ns/1ps
module hpa_sum_back
  import hybrid_prefix_adder_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W:1]   p_bits,
  input  logic [W-1:0] carry_bits,
  output logic [W-1:0] sum
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = bit_prop(p_bits[i+1], carry_bits[i]);
  end
endmodule

// File: rtl/hybrid_prefix_adder.sv
`timescale 1ns/1ps
module hybrid_prefix_adder
  import hybrid_prefix_adder_pkg::*;
#(
  parameter int W          = 16,
  parameter int LOW_SPAN   = 8,
  parameter bit LOW_RIPPLE = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int HI_SPAN = W + 1 - LOW_SPAN;

  logic [W:0]          node_g;
  logic [W:1]          node_p;
  logic [LOW_SPAN-1:0] lo_grp;
  logic [HI_SPAN-1:0]  hi_g;
  logic [HI_SPAN-1:0]  hi_p;
  logic [W:0]          carry;   // carry[i] enters bit i; carry[W] leaves the word

  hpa_gp_front #(.W(W)) u_front (
    .a      (a),
    .b      (b),
    .cin    (cin),
    .node_g (node_g),
    .node_p (node_p)
  );

  hpa_low_tree #(.N(LOW_SPAN), .RIPPLE(LOW_RIPPLE)) u_low (
    .g_in (node_g[LOW_SPAN-1:0]),
    .p_in (node_p[LOW_SPAN-1:1]),
    .grp  (lo_grp)
  );

  hpa_high_tree #(.N(HI_SPAN)) u_high (
    .g_in  (node_g[W:LOW_SPAN]),
    .p_in  (node_p[W:LOW_SPAN]),
    .grp_g (hi_g),
    .grp_p (hi_p)
  );

  assign carry[LOW_SPAN-1:0] = lo_grp;

  // generate-only join of each upper group with the lower segment carry
  for (genvar k = 0; k < HI_SPAN; k++) begin : g_join
    assign carry[LOW_SPAN+k] = merge2_g(hi_g[k], hi_p[k], lo_grp[LOW_SPAN-1]);
  end

  hpa_sum_back #(.W(W)) u_back (
    .p_bits     (node_p),
    .carry_bits (carry[W-1:0]),
    .sum        (sum)
  );

  assign cout = carry[W];
endmodule

// File: rtl/hybrid_prefix_adder_chk.sv
`timescale 1ns/1ps
module hybrid_prefix_adder_chk #(
  parameter int W        = 16,
  parameter int LOW_SPAN = 8
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         cin,
  input logic [W-1:0] sum,
  input logic         cout,
  input logic [W:0]   carry
);
  logic [W:0]          full_ref;
  logic [LOW_SPAN:0]   low_ref;

  always_comb begin
    full_ref = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    low_ref  = {1'b0, a[LOW_SPAN-1:0]} + {1'b0, b[LOW_SPAN-1:0]} + {{LOW_SPAN{1'b0}}, cin};

    assert_total_R1: assert ({cout, sum} == full_ref)
      else $error("R1 total mismatch");

    assert_lsb_R2: assert (sum[0] == (a[0] ^ b[0] ^ cin))
      else $error("R2 bit 0 mismatch");

    if (&(a ^ b)) begin
      assert_all_prop_R3: assert (cout == cin)
        else $error("R3 propagate-through mismatch");
    end

    for (int k = 0; k < W; k++) begin
      // the tree carry must satisfy the ripple recurrence at every position (R1)
      assert_carry_step_R1: assert (carry[k+1] == ((a[k] & b[k]) | ((a[k] ^ b[k]) & carry[k])))
        else $error("R1 carry recurrence broken at bit %0d", k);
    end

    assert_low_part_R6: assert (sum[LOW_SPAN-1:0] == low_ref[LOW_SPAN-1:0] &&
                                carry[LOW_SPAN] == low_ref[LOW_SPAN])
      else $error("R6 lower segment mismatch");
  end
endmodule

bind hybrid_prefix_adder hybrid_prefix_adder_chk #(.W(W), .LOW_SPAN(LOW_SPAN)) u_chk (
  .a     (a),
  .b     (b),
  .cin   (cin),
  .sum   (sum),
  .cout  (cout),
  .carry (carry)
);

// File: tb/hybrid_prefix_adder_bench.sv
`timescale 1ns/1ps
module hybrid_prefix_adder_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] a, b, sum;
  logic        cin, cout;
  int          checks = 0;
  int          errors = 0;
  int          exp_q[$];

  always #2.5 clk = ~clk;

  hybrid_prefix_adder u_hybrid_prefix_adder (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );

  function automatic int model(input int x, input int y, input int c);
    return x + y + c;
  endfunction

  task automatic drive(input logic [15:0] x, input logic [15:0] y, input logic c);
    @(posedge clk);
    #1;
    a = x; b = y; cin = c;
    exp_q.push_back(model(int'(x), int'(y), int'(c)));
  endtask

  task automatic compare(input string req);
    int exp;
    int got;
    @(negedge clk);
    exp = exp_q.pop_front();
    got = int'({cout, sum});
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %05h expected %05h", req, got, exp);
    end
  endtask

  task automatic vec(input logic [15:0] x, input logic [15:0] y, input logic c, input string req);
    drive(x, y, c);
    compare(req);
  endtask

  task automatic expect_val(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %05h expected %05h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] low_first;
    rst = 1'b1;
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: zero operands, zero carry
    expect_val("R8 reset-time zero", int'({cout, sum}), 0);
    rst = 1'b0;

    vec(16'h0000, 16'h0000, 1'b1, "R8 carry only");
    expect_val("R8 carry only sum", int'(sum), 1);
    vec(16'h0001, 16'h0000, 1'b1, "R2 lsb with carry");
    expect_val("R2 sum0", int'(sum[0]), 0);
    vec(16'h0000, 16'h0001, 1'b0, "R2 lsb no carry");
    expect_val("R2 sum0b", int'(sum[0]), 1);

    // R3: every position propagates
    vec(16'hAAAA, 16'h5555, 1'b0, "R3 alt pattern cin0");
    expect_val("R3 cout follows cin0", int'(cout), 0);
    vec(16'hAAAA, 16'h5555, 1'b1, "R3 alt pattern cin1");
    expect_val("R3 cout follows cin1", int'(cout), 1);
    vec(16'hF0F0, 16'h0F0F, 1'b1, "R3 nibble pattern");
    expect_val("R3 sum zero", int'(sum), 0);

    // R4: both all ones
    vec(16'hFFFF, 16'hFFFF, 1'b0, "R4 ones cin0");
    vec(16'hFFFF, 16'hFFFF, 1'b1, "R4 ones cin1");
    expect_val("R4 sum ones", int'(sum), 16'hFFFF);

    // R5: full-length carry
    vec(16'hFFFF, 16'h0001, 1'b0, "R5 ffff plus one");
    expect_val("R5 cout", int'(cout), 1);
    vec(16'hFFFF, 16'h0000, 1'b1, "R5 ffff plus cin");
    vec(16'hAAAA, 16'hAAAA, 1'b0, "R1 same alt");
    vec(16'h5555, 16'h5555, 1'b1, "R1 same alt other");

    // R6: lower byte isolated from upper operands, and carry into bit 8
    vec(16'h00FF, 16'h0001, 1'b0, "R6 byte carry");
    expect_val("R6 bit8", int'(sum), 16'h0100);
    vec(16'h7F3C, 16'h80A9, 1'b1, "R6 low first");
    low_first = sum[7:0];
    vec(16'h013C, 16'hEEA9, 1'b1, "R6 low second");
    expect_val("R6 low unchanged", int'(sum[7:0]), int'(low_first));

    // R7: no clock edge between a change and its result
    @(posedge clk);
    #1;
    a = 16'h1234; b = 16'h4321; cin = 1'b1;
    #0.5;
    expect_val("R7 immediate", int'({cout, sum}), model(16'h1234, 16'h4321, 1));
    a = 16'h8000; b = 16'h8000; cin = 1'b0;
    #0.5;
    expect_val("R7 immediate second", int'({cout, sum}), 32'h10000);

    // R1: random sweep, one vector per clock
    for (int n = 0; n < 100000; n++) begin
      vec(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");
    end

    finish_run();
  end
endmodule